// File: doc/BRIEF.md
# Embedded Operation Status Generator

This block forms the status byte that a flash array returns on reads while an embedded program or erase runs, while it has failed on a timeout, or while an erase is suspended. It also drives the active-low ready/busy output. One instance covers one byte lane, and a 16-bit device uses two instances side by side. An operation engine outside the block runs the erase and program algorithms and counts pulses. That engine tells the block when an operation starts, finishes or times out, which sectors are queued for erase, whether the erase accumulation window is still open, and which address is being programmed.

When no operation is active, every read returns the array data on `arrayData` unchanged. During an operation, each read access is marked by a one-cycle `readStrobe`. A read returns a status byte with these bits:

- bit 7: complement polling.
- bit 6: a toggle that changes on every read.
- bit 5: timeout.
- bit 3: erase window.
- bit 2: a toggle local to the sectors being erased.

During erase suspend, reads from sectors that are not suspended return array data again. An embedded program can be started inside a suspend and is reported on its own.

Top module: `flash_op_status`

## Requirements
- R1: While `rstN` is low, `busyN` is low. After `rstN` returns high, `busyN` is high and `dataOut` equals `arrayData`.
- R2: A `progStart` accepted while idle makes `busyN` low from the next cycle. Bit 7 then reads the inverse of the `progBit7` value captured with the start. Bit 2 reads 1. On `opDone`, `busyN` returns high and reads return `arrayData`.
- R3: While an operation is busy (program, erase, program within suspend, or failed), bit 6 inverts after every read strobe. Once the block is idle, bit 6 is plain array data.
- R4: During an erase, `busyN` is low and bit 7 reads 0.
- R5: During an erase, bit 3 reads the inverse of `windowOpen`: 0 while sectors can still be queued, and 1 once the internal erase has begun.
- R6: During an erase, bit 2 inverts on each read whose sector field (`readAddr[ADDR_W-1 -: log2(SECTORS)]`) selects a set bit of `eraseSectorMask`. Bit 2 is unchanged by reads of other sectors. A chip erase (`chipErase` high at start) treats every sector as selected.
- R7: `opTimeout` moves the block to a failed state. In that state bit 5 reads 1, `busyN` stays low and bit 6 keeps toggling. A program failure reports bit 7 as the complement and bit 3 as 0. The state ignores `opDone` and is left only by `resetCmd`, which has no effect while a program or erase runs normally.
- R8: `suspendCmd` during a sector erase makes `busyN` high. Reads from sectors outside the mask return `arrayData`. Reads from masked sectors return a status with bit 7 = 1, bit 3 = 1 and bit 6 held, while bit 2 still inverts per read.
- R9: `suspendCmd` is ignored during a program and during a chip erase: `busyN` stays low.
- R10: A `progStart` while suspended makes `busyN` low. Reads at `progAddr` show bit 7 as the complement of the captured `progBit7`, bit 2 = 1, and a toggling bit 6. `opDone` returns the block to suspend with `busyN` high.
- R11: `resumeCmd` in suspend brings back the erase: `busyN` is low and the status again follows R4 and R5.
- R12: In every status byte, bits 4, 1 and 0 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low hardware reset, synchronous to `clk` |
| progStart | input | 1 | Pulse: the final write of a program sequence has been taken |
| eraseStart | input | 1 | Pulse: the final write of an erase sequence has been taken |
| chipErase | input | 1 | Sampled with `eraseStart`: 1 selects a whole-chip erase |
| opDone | input | 1 | Pulse: the running program or erase finished |
| opTimeout | input | 1 | Pulse: the running operation exceeded its internal limit |
| suspendCmd | input | 1 | Pulse: an erase suspend command was written |
| resumeCmd | input | 1 | Pulse: an erase resume command was written |
| resetCmd | input | 1 | Pulse: a reset command was written |
| progBit7 | input | 1 | Bit 7 of the data being programmed, sampled with `progStart` |
| windowOpen | input | 1 | High while the sector-erase accumulation window is open |
| eraseSectorMask | input | SECTORS | One bit per sector queued for erase |
| progAddr | input | ADDR_W | Address being programmed |
| readStrobe | input | 1 | One-cycle pulse marking a read access |
| readAddr | input | ADDR_W | Address of the read access |
| arrayData | input | 8 | Array data for this lane |
| dataOut | output | 8 | Read data: array data or status byte |
| busyN | output | 1 | Active-low ready/busy |

## Verification
The toggle bits are driven with pairs of successive reads. Comparing the two results separates the global toggle from the sector-local toggle:

- Reading the same masked sector twice shows bit 2 inverting.
- Reading an unmasked sector twice shows bit 2 holding.
- Reading during a suspend shows bit 6 holding, while reading during a program within that suspend shows bit 6 inverting.

Fixed array data that differs from every status value shows whether a read was passed through or replaced. Polling data of both polarities checks that bit 7 is the complement. Commands sent in states that must ignore them are followed by a look at `busyN` and the status byte:

- suspend during a program and during a chip erase;
- reset during a program;
- done during a failure.

// File: rtl/flash_op_status_pkg.sv
package flash_op_status_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PROG,
    ST_ERASE,
    ST_SUSP,
    ST_SUSPPROG,
    ST_FAIL
  } opState_t;

  // Per-cycle strobes from control to datapath
  typedef struct packed {
    logic flipGlobal;   // invert the all-reads toggle
    logic flipLocal;    // invert the sector-local toggle
    logic capturePoll;  // capture the complemented polling bit
  } ctrlStrobe_t;

endpackage

// File: rtl/flash_op_status_ctrl.sv
module flash_op_status_ctrl
  import flash_op_status_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        progStart,
  input  logic        eraseStart,
  input  logic        chipErase,
  input  logic        opDone,
  input  logic        opTimeout,
  input  logic        suspendCmd,
  input  logic        resumeCmd,
  input  logic        resetCmd,
  input  logic        readStrobe,
  input  logic        sectorHit,
  input  logic        progHit,
  output opState_t    opState,
  output logic        failErase,
  output logic        chipMode,
  output logic        busyState,
  output ctrlStrobe_t strobe
);

  opState_t nextState;
  logic     nextFailErase;

  always_comb begin
    nextState     = opState;
    nextFailErase = failErase;
    unique case (opState)
      ST_IDLE: begin
        if (progStart)       nextState = ST_PROG;
        else if (eraseStart) nextState = ST_ERASE;
      end
      ST_PROG: begin
        if (opTimeout) begin
          nextState     = ST_FAIL;
          nextFailErase = 1'b0;
        end else if (opDone) begin
          nextState = ST_IDLE;
        end
      end
      ST_ERASE: begin
        if (opTimeout) begin
          nextState     = ST_FAIL;
          nextFailErase = 1'b1;
        end else if (opDone) begin
          nextState = ST_IDLE;
        end else if (suspendCmd && !chipMode) begin
          nextState = ST_SUSP;
        end
      end
      ST_SUSP: begin
        if (resumeCmd)      nextState = ST_ERASE;
        else if (progStart) nextState = ST_SUSPPROG;
      end
      ST_SUSPPROG: begin
        if (opTimeout) begin
          nextState     = ST_FAIL;
          nextFailErase = 1'b0;
        end else if (opDone) begin
          nextState = ST_SUSP;
        end
      end
      ST_FAIL: begin
        if (resetCmd) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opState   <= ST_IDLE;
      failErase <= 1'b0;
      chipMode  <= 1'b0;
    end else begin
      opState   <= nextState;
      failErase <= nextFailErase;
      if (opState == ST_IDLE && eraseStart && !progStart)
        chipMode <= chipErase;
    end
  end

  always_comb begin
    busyState = (opState == ST_PROG) || (opState == ST_ERASE) ||
                (opState == ST_SUSPPROG) || (opState == ST_FAIL);
    strobe.flipGlobal  = readStrobe && busyState;
    strobe.flipLocal   = readStrobe && sectorHit &&
                         ((opState == ST_ERASE) || (opState == ST_SUSP) ||
                          ((opState == ST_SUSPPROG) && !progHit));
    strobe.capturePoll = progStart &&
                         ((opState == ST_IDLE) || (opState == ST_SUSP));
  end

endmodule

// File: rtl/flash_op_status_datapath.sv
module flash_op_status_datapath
  import flash_op_status_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int SECTORS = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  opState_t           opState,
  input  logic               failErase,
  input  logic               chipMode,
  input  ctrlStrobe_t        strobe,
  input  logic               progBit7,
  input  logic               windowOpen,
  input  logic [SECTORS-1:0] eraseSectorMask,
  input  logic [ADDR_W-1:0]  progAddr,
  input  logic [ADDR_W-1:0]  readAddr,
  input  logic [7:0]         arrayData,
  output logic               sectorHit,
  output logic               progHit,
  output logic [7:0]         dataOut
);

  localparam int SECT_W = $clog2(SECTORS);

  logic [SECT_W-1:0] readSector;
  logic              pollInv;
  logic              tglGlobal;
  logic              tglLocal;
  logic [7:0]        statusByte;
  logic              showStatus;

  assign readSector = readAddr[ADDR_W-1 -: SECT_W];
  assign sectorHit  = chipMode || eraseSectorMask[readSector];
  assign progHit    = (readAddr == progAddr);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pollInv   <= 1'b0;
      tglGlobal <= 1'b0;
      tglLocal  <= 1'b0;
    end else begin
      if (strobe.capturePoll) pollInv   <= ~progBit7;
      if (strobe.flipGlobal)  tglGlobal <= ~tglGlobal;
      if (strobe.flipLocal)   tglLocal  <= ~tglLocal;
    end
  end

  always_comb begin
    statusByte    = 8'h00;
    statusByte[6] = tglGlobal;
    showStatus    = 1'b1;
    unique case (opState)
      ST_IDLE: showStatus = 1'b0;
      ST_PROG: begin
        statusByte[7] = pollInv;
        statusByte[2] = 1'b1;
      end
      ST_ERASE: begin
        statusByte[7] = 1'b0;
        statusByte[3] = ~windowOpen;
        statusByte[2] = tglLocal;
      end
      ST_SUSP: begin
        showStatus    = sectorHit;
        statusByte[7] = 1'b1;
        statusByte[3] = 1'b1;
        statusByte[2] = tglLocal;
      end
      ST_SUSPPROG: begin
        statusByte[7] = pollInv;
        statusByte[2] = progHit ? 1'b1 : tglLocal;
      end
      ST_FAIL: begin
        statusByte[7] = failErase ? 1'b0 : pollInv;
        statusByte[5] = 1'b1;
        statusByte[3] = failErase;
        statusByte[2] = tglLocal;
      end
      default: showStatus = 1'b0;
    endcase
    dataOut = showStatus ? statusByte : arrayData;
  end

endmodule

// File: rtl/flash_op_status.sv
module flash_op_status
  import flash_op_status_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int SECTORS = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               progStart,
  input  logic               eraseStart,
  input  logic               chipErase,
  input  logic               opDone,
  input  logic               opTimeout,
  input  logic               suspendCmd,
  input  logic               resumeCmd,
  input  logic               resetCmd,
  input  logic               progBit7,
  input  logic               windowOpen,
  input  logic [SECTORS-1:0] eraseSectorMask,
  input  logic [ADDR_W-1:0]  progAddr,
  input  logic               readStrobe,
  input  logic [ADDR_W-1:0]  readAddr,
  input  logic [7:0]         arrayData,
  output logic [7:0]         dataOut,
  output logic               busyN
);

  opState_t    opState;
  ctrlStrobe_t strobe;
  logic        failErase;
  logic        chipMode;
  logic        busyState;
  logic        sectorHit;
  logic        progHit;

  flash_op_status_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .progStart  (progStart),
    .eraseStart (eraseStart),
    .chipErase  (chipErase),
    .opDone     (opDone),
    .opTimeout  (opTimeout),
    .suspendCmd (suspendCmd),
    .resumeCmd  (resumeCmd),
    .resetCmd   (resetCmd),
    .readStrobe (readStrobe),
    .sectorHit  (sectorHit),
    .progHit    (progHit),
    .opState    (opState),
    .failErase  (failErase),
    .chipMode   (chipMode),
    .busyState  (busyState),
    .strobe     (strobe)
  );

  flash_op_status_datapath #(
    .ADDR_W  (ADDR_W),
    .SECTORS (SECTORS)
  ) u_dp (
    .clk             (clk),
    .rstN            (rstN),
    .opState         (opState),
    .failErase       (failErase),
    .chipMode        (chipMode),
    .strobe          (strobe),
    .progBit7        (progBit7),
    .windowOpen      (windowOpen),
    .eraseSectorMask (eraseSectorMask),
    .progAddr        (progAddr),
    .readAddr        (readAddr),
    .arrayData       (arrayData),
    .sectorHit       (sectorHit),
    .progHit         (progHit),
    .dataOut         (dataOut)
  );

  // Busy is forced low during hardware reset regardless of state
  assign busyN = rstN && !busyState;

endmodule

// File: rtl/flash_op_status_chk.sv
module flash_op_status_chk (
  input logic       clk,
  input logic       rstN,
  input logic       progStart,
  input logic       opDone,
  input logic       suspendCmd,
  input logic       resetCmd,
  input logic       readStrobe,
  input logic [7:0] dataOut,
  input logic       busyN
);

  // R1: busy shown while hardware reset is held
  always @(posedge clk) begin
    if (rstN === 1'b0)
      assert_busy_in_reset_R1: assert (busyN === 1'b0);
  end

  // R2: accepted program start turns busy on next cycle
  assert_prog_busy_R2: assert property (@(posedge clk) disable iff (!rstN)
    (progStart && busyN) |=> !busyN);

  // R3: bit 6 inverts after a read while busy and the state holds
  assert_toggle_flip_R3: assert property (@(posedge clk) disable iff (!rstN)
    (readStrobe && !busyN && !opDone && !resetCmd && !suspendCmd)
      |=> (dataOut[6] != $past(dataOut[6])));

  // R7: failure state is sticky until reset command
  assert_fail_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    (dataOut[5] && !busyN && !resetCmd) |=> (dataOut[5] && !busyN));

  // R12: unused status bits stay zero whenever status is shown by busy
  assert_zero_bits_R12: assert property (@(posedge clk) disable iff (!rstN)
    !busyN |-> (dataOut[4] == 1'b0 && dataOut[1:0] == 2'b00));

endmodule

bind flash_op_status flash_op_status_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .progStart  (progStart),
  .opDone     (opDone),
  .suspendCmd (suspendCmd),
  .resetCmd   (resetCmd),
  .readStrobe (readStrobe),
  .dataOut    (dataOut),
  .busyN      (busyN)
);

// File: tb/sim_flash_op_status.sv
module sim_flash_op_status;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 20;
  localparam int SECTORS    = 16;
  localparam logic [7:0] ARRAY = 8'h5A;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               progStart = 1'b0;
  logic               eraseStart = 1'b0;
  logic               chipErase = 1'b0;
  logic               opDone = 1'b0;
  logic               opTimeout = 1'b0;
  logic               suspendCmd = 1'b0;
  logic               resumeCmd = 1'b0;
  logic               resetCmd = 1'b0;
  logic               progBit7 = 1'b0;
  logic               windowOpen = 1'b0;
  logic [SECTORS-1:0] eraseSectorMask = '0;
  logic [ADDR_W-1:0]  progAddr = '0;
  logic               readStrobe = 1'b0;
  logic [ADDR_W-1:0]  readAddr = '0;
  logic [7:0]         arrayData = ARRAY;
  logic [7:0]         dataOut;
  logic               busyN;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_op_status #(.ADDR_W(ADDR_W), .SECTORS(SECTORS)) u0 (
    .clk(clk), .rstN(rstN), .progStart(progStart), .eraseStart(eraseStart),
    .chipErase(chipErase), .opDone(opDone), .opTimeout(opTimeout),
    .suspendCmd(suspendCmd), .resumeCmd(resumeCmd), .resetCmd(resetCmd),
    .progBit7(progBit7), .windowOpen(windowOpen),
    .eraseSectorMask(eraseSectorMask), .progAddr(progAddr),
    .readStrobe(readStrobe), .readAddr(readAddr), .arrayData(arrayData),
    .dataOut(dataOut), .busyN(busyN)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doRead(logic [ADDR_W-1:0] addr, output logic [7:0] v);
    readAddr   = addr;
    readStrobe = 1'b1;
    #1 v = dataOut;
    step();
    readStrobe = 1'b0;
  endtask

  task automatic testReset();
    rstN = 1'b0;
    step(); step();
    chk("R1 busy during reset", {7'b0, busyN}, 8'h00);
    rstN = 1'b1;
    step();
    chk("R1 busy after reset", {7'b0, busyN}, 8'h01);
    chk("R1 data passthrough", dataOut, ARRAY);
  endtask

  task automatic testProgram();
    logic [7:0] a, b;
    progBit7 = 1'b1; progStart = 1'b1; step(); progStart = 1'b0;
    chk("R2 busy after start", {7'b0, busyN}, 8'h00);
    doRead(20'h12345, a); doRead(20'h12345, b);
    chk("R2 polling status", a & 8'hBF, 8'h04);
    chk("R12 zero bits", a & 8'h13, 8'h00);
    chk("R3 bit6 toggles in program", (a ^ b) & 8'h40, 8'h40);
    suspendCmd = 1'b1; step(); suspendCmd = 1'b0;
    chk("R9 suspend ignored in program", {7'b0, busyN}, 8'h00);
    resetCmd = 1'b1; step(); resetCmd = 1'b0;
    chk("R7 reset cmd ignored in program", {7'b0, busyN}, 8'h00);
    opDone = 1'b1; step(); opDone = 1'b0;
    chk("R2 ready after done", {7'b0, busyN}, 8'h01);
    doRead(20'h12345, a); doRead(20'h12345, b);
    chk("R2 passthrough after done", a, ARRAY);
    chk("R3 bit6 still after done", (a ^ b) & 8'h40, 8'h00);
  endtask

  task automatic testEraseSuspend();
    logic [7:0] a, b;
    eraseSectorMask = 16'h0008; windowOpen = 1'b1; chipErase = 1'b0;
    eraseStart = 1'b1; step(); eraseStart = 1'b0;
    chk("R4 busy in erase", {7'b0, busyN}, 8'h00);
    doRead(20'h30000, a); doRead(20'h30000, b);
    chk("R4 R5 erase status window open", a & 8'hBB, 8'h00);
    chk("R6 bit2 toggles masked sector", (a ^ b) & 8'h04, 8'h04);
    chk("R3 bit6 toggles in erase", (a ^ b) & 8'h40, 8'h40);
    doRead(20'h50000, a); doRead(20'h50000, b);
    chk("R6 bit2 holds other sector", (a ^ b) & 8'h04, 8'h00);
    windowOpen = 1'b0;
    doRead(20'h30000, a);
    chk("R5 window closed", a & 8'h08, 8'h08);
    suspendCmd = 1'b1; step(); suspendCmd = 1'b0;
    chk("R8 ready in suspend", {7'b0, busyN}, 8'h01);
    doRead(20'h50000, a);
    chk("R8 other sector array data", a, ARRAY);
    doRead(20'h30000, a); doRead(20'h30000, b);
    chk("R8 suspended sector status", a & 8'hBB, 8'h88);
    chk("R8 bit6 held", (a ^ b) & 8'h40, 8'h00);
    chk("R8 bit2 toggles", (a ^ b) & 8'h04, 8'h04);
    progBit7 = 1'b0; progAddr = 20'h50010;
    progStart = 1'b1; step(); progStart = 1'b0;
    chk("R10 busy in suspend program", {7'b0, busyN}, 8'h00);
    doRead(20'h50010, a); doRead(20'h50010, b);
    chk("R10 status at program address", a & 8'hBF, 8'h84);
    chk("R10 bit6 toggles", (a ^ b) & 8'h40, 8'h40);
    opDone = 1'b1; step(); opDone = 1'b0;
    chk("R10 back to suspend", {7'b0, busyN}, 8'h01);
    resumeCmd = 1'b1; step(); resumeCmd = 1'b0;
    chk("R11 busy after resume", {7'b0, busyN}, 8'h00);
    doRead(20'h30000, a);
    chk("R11 erase status after resume", a & 8'hBB, 8'h08);
    opDone = 1'b1; step(); opDone = 1'b0;
    chk("R4 erase done ready", {7'b0, busyN}, 8'h01);
    chk("R4 passthrough after erase", dataOut, ARRAY);
  endtask

  task automatic testTimeout();
    logic [7:0] a, b;
    progBit7 = 1'b0; progStart = 1'b1; step(); progStart = 1'b0;
    opTimeout = 1'b1; step(); opTimeout = 1'b0;
    doRead(20'h00100, a); doRead(20'h00100, b);
    chk("R7 fail status", a & 8'hBB, 8'hA0);
    chk("R7 bit6 keeps toggling", (a ^ b) & 8'h40, 8'h40);
    opDone = 1'b1; step(); opDone = 1'b0;
    chk("R7 done ignored busy", {7'b0, busyN}, 8'h00);
    chk("R7 done ignored status", dataOut & 8'hBB, 8'hA0);
    resetCmd = 1'b1; step(); resetCmd = 1'b0;
    chk("R7 reset cmd clears", {7'b0, busyN}, 8'h01);
    chk("R7 passthrough after clear", dataOut, ARRAY);
  endtask

  task automatic testChipErase();
    logic [7:0] a, b;
    eraseSectorMask = '0; chipErase = 1'b1; windowOpen = 1'b0;
    eraseStart = 1'b1; step(); eraseStart = 1'b0; chipErase = 1'b0;
    doRead(20'h50000, a); doRead(20'h50000, b);
    chk("R6 chip erase bit2 toggles", (a ^ b) & 8'h04, 8'h04);
    suspendCmd = 1'b1; step(); suspendCmd = 1'b0;
    chk("R9 suspend ignored in chip erase", {7'b0, busyN}, 8'h00);
    opDone = 1'b1; step(); opDone = 1'b0;
    chk("R4 chip erase done", {7'b0, busyN}, 8'h01);
  endtask

  initial begin
    #1;
    testReset();
    testProgram();
    testEraseSuspend();
    testTimeout();
    testChipErase();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired R1 actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule